// File: doc/BRIEF.md
# Byte-Wide Serial Port with Line Status

A single-module asynchronous serial transmitter/receiver for byte data, reached through a three-register memory-mapped window with read and write strobes and a two-bit address.

Software writes a byte into a holding register. The byte moves into a shift register on the next baud tick, and the shift register sends a start bit, eight data bits least significant first, an optional even-parity bit and a stop bit. The receiver samples its input 16 times per bit, finds the middle of each bit, rejects short start glitches and places each finished character into a receive buffer.

An eight-bit read-only status register reports data-ready and the receive errors (overrun, parity, framing, break). It also reports two transmitter flags: one for an empty holding register and one for an idle transmitter. An eight-bit control register holds a loopback enable and two software-driven active-low modem outputs. In loopback the serial output pin is parked high, and the transmitted stream feeds the receiver in place of the input pin. Baud timing comes from a fixed clock divider that produces one oversampling tick every `CLK_DIV` clocks.

Top module: `uart_core`

## Requirements
- R1: After reset the status register (address 2) reads 0x60, the control register (address 1) reads 0x00, and `tx_o`, `rts_n_o` and `dtr_n_o` are all high.
- R2: A byte written to address 0 is sent on `tx_o` as a low start bit, eight data bits LSB first, a parity bit that makes the count of ones over data and parity even (when `PARITY_EN` is 1), and a high stop bit. Each bit lasts `CLK_DIV*OVS` clocks. The line idles high.
- R3: Status bit 5 reads 1 exactly when the holding register is empty. It drops on a write to address 0 and rises when the byte moves into the shift register, even while that byte is still being sent.
- R4: Status bit 6 reads 1 only when both the holding register and the shift register are empty.
- R5: A write to address 0 while status bit 5 is 0 replaces the pending byte, so only the newest byte is sent.
- R6: When a character completes, the receive buffer (read at address 0) holds it and status bit 0 sets. Reading address 0 clears bit 0.
- R7: Status bit 2 sets when the received parity bit does not give even parity over data and parity.
- R8: Status bit 3 sets when the sampled stop bit is low.
- R9: Status bit 1 sets when a character completes while status bit 0 is still set. The buffer then holds the newer character.
- R10: Status bit 4 sets when the receive input stays low for more than `FRAME_BITS*OVS` oversampling ticks (11 bit times with parity). A valid 0x00 character does not set it.
- R11: A read of address 2 clears status bits 4 to 1, and status bit 0 stays unchanged.
- R12: With control bit 4 set, `tx_o` is held high, the transmitted stream is received internally, and `rx_i` is ignored.
- R13: Control bit 1 set drives `rts_n_o` low and clear drives it high. Control bit 0 does the same for `dtr_n_o`. The control register reads back bits 4, 1 and 0, and all other bits read 0.
- R14: A low pulse on `rx_i` shorter than half a bit time is not taken as a start bit and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| wr_en | input | 1 | Write strobe, one clock per access |
| rd_en | input | 1 | Read strobe, carries read side effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output |
| rts_n_o | output | 1 | Active-low request-to-send |
| dtr_n_o | output | 1 | Active-low data-terminal-ready |

## Verification
Some properties are checked on every cycle:
- a write to the data address always fills the holding register;
- the loopback output stays high;
- a completed frame ends on a high stop bit;
- reading the buffer drops data-ready unless a character lands in the same clock;
- overrun follows a completion onto an unread buffer;
- a status read leaves no error flag behind unless a new event coincides;
- the modem pins follow the last control write.

Other behaviour only the bench scenarios can show:
- the exact serial waveform and both empty flags, matched clock for clock against a behavioural transmitter;
- the overwrite of a pending byte, seen through loopback;
- parity, framing and break detection on hand-built frames;
- rejection of a short start glitch;
- a legal all-zero character raising no break.

// File: rtl/uart_core.sv
module uart_core #(
  parameter int CLK_DIV   = 4,
  parameter int OVS       = 16,
  parameter int PARITY_EN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       rts_n_o,
  output logic       dtr_n_o
);
  localparam int DIVW       = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int OVSW       = $clog2(OVS);
  localparam int FRAME_BITS = (PARITY_EN != 0) ? 11 : 10;
  localparam int FBW        = $clog2(FRAME_BITS);
  localparam int BRK_TICKS  = FRAME_BITS * OVS;
  localparam int BRKW       = $clog2(BRK_TICKS + 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD} rx_st_t;

  logic [DIVW-1:0] div_cnt;
  wire tick = (div_cnt == DIVW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;

  wire wr_thr = wr_en && (addr == 2'd0);
  wire wr_ctl = wr_en && (addr == 2'd1);
  wire rd_rbr = rd_en && (addr == 2'd0);
  wire rd_sta = rd_en && (addr == 2'd2);

  logic lb, rts, dtr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {lb, rts, dtr} <= 3'b000;
    else if (wr_ctl) {lb, rts, dtr} <= {wdata[4], wdata[1], wdata[0]};

  assign rts_n_o = ~rts;
  assign dtr_n_o = ~dtr;

  function automatic logic [FRAME_BITS-1:0] mk_frame(input logic [7:0] d);
    logic [10:0] with_par;
    logic [9:0]  no_par;
    with_par = {1'b1, ^d, d, 1'b0};
    no_par   = {1'b1, d, 1'b0};
    return (PARITY_EN != 0) ? FRAME_BITS'(with_par) : FRAME_BITS'(no_par);
  endfunction

  logic [7:0]            thr;
  logic                  thr_full, tx_busy;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [OVSW-1:0]       tx_ovs;
  logic [FBW-1:0]        tx_bitn;
  wire tx_load = tick && !tx_busy && thr_full;
  wire tx_line = tx_busy ? tx_sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
    end else if (wr_thr) begin
      thr      <= wdata;
      thr_full <= 1'b1;
    end else if (tx_load) begin
      thr_full <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sr   <= '1;
      tx_ovs  <= '0;
      tx_bitn <= '0;
    end else if (tick) begin
      if (!tx_busy) begin
        if (thr_full) begin
          tx_sr   <= mk_frame(thr);
          tx_busy <= 1'b1;
          tx_ovs  <= '0;
          tx_bitn <= '0;
        end
      end else if (tx_ovs == OVSW'(OVS - 1)) begin
        tx_ovs <= '0;
        tx_sr  <= {1'b1, tx_sr[FRAME_BITS-1:1]};
        if (tx_bitn == FBW'(FRAME_BITS - 1)) tx_busy <= 1'b0;
        else tx_bitn <= tx_bitn + 1'b1;
      end else begin
        tx_ovs <= tx_ovs + 1'b1;
      end
    end

  assign tx_o = lb ? 1'b1 : tx_line;

  logic [1:0] rx_meta;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_meta <= 2'b11;
    else        rx_meta <= {rx_meta[0], rx_i};

  wire rx_bit = lb ? tx_line : rx_meta[1];

  rx_st_t          rx_st;
  logic [OVSW-1:0] rx_ovs;
  logic [2:0]      rx_bitn;
  logic [7:0]      rx_sr, rbr;
  logic            rx_par;
  wire rx_mid  = (rx_ovs == OVSW'(OVS - 1));
  wire rx_half = (rx_ovs == OVSW'(OVS / 2 - 1));
  wire rx_load = tick && (rx_st == RX_STOP) && rx_mid;
  wire par_bad = (PARITY_EN != 0) && (rx_par != ^rx_sr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st   <= RX_IDLE;
      rx_ovs  <= '0;
      rx_bitn <= '0;
      rx_sr   <= '0;
      rx_par  <= 1'b0;
    end else if (tick) begin
      case (rx_st)
        RX_IDLE:
          if (!rx_bit) begin
            rx_st  <= RX_START;
            rx_ovs <= '0;
          end
        RX_START:
          if (rx_bit) rx_st <= RX_IDLE;
          else if (rx_half) begin
            rx_st   <= RX_DATA;
            rx_ovs  <= '0;
            rx_bitn <= '0;
          end else rx_ovs <= rx_ovs + 1'b1;
        RX_DATA:
          if (rx_mid) begin
            rx_ovs <= '0;
            rx_sr  <= {rx_bit, rx_sr[7:1]};
            if (rx_bitn == 3'd7) rx_st <= (PARITY_EN != 0) ? RX_PAR : RX_STOP;
            else rx_bitn <= rx_bitn + 1'b1;
          end else rx_ovs <= rx_ovs + 1'b1;
        RX_PAR:
          if (rx_mid) begin
            rx_ovs <= '0;
            rx_par <= rx_bit;
            rx_st  <= RX_STOP;
          end else rx_ovs <= rx_ovs + 1'b1;
        RX_STOP:
          if (rx_mid) begin
            rx_ovs <= '0;
            rx_st  <= rx_bit ? RX_IDLE : RX_HOLD;
          end else rx_ovs <= rx_ovs + 1'b1;
        RX_HOLD:
          if (rx_bit) rx_st <= RX_IDLE;
        default: rx_st <= RX_IDLE;
      endcase
    end

  logic [BRKW-1:0] brk_cnt;
  wire bi_hit = tick && !rx_bit && (brk_cnt == BRKW'(BRK_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) brk_cnt <= '0;
    else if (tick) begin
      if (rx_bit) brk_cnt <= '0;
      else if (brk_cnt != BRKW'(BRK_TICKS)) brk_cnt <= brk_cnt + 1'b1;
    end

  logic dr, oe, pe, fe, bi;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbr <= '0;
      dr  <= 1'b0;
      oe  <= 1'b0;
      pe  <= 1'b0;
      fe  <= 1'b0;
      bi  <= 1'b0;
    end else begin
      if (rx_load) rbr <= rx_sr;
      dr <= rx_load ? 1'b1 : (rd_rbr ? 1'b0 : dr);
      oe <= (rx_load && dr && !rd_rbr) ? 1'b1 : (rd_sta ? 1'b0 : oe);
      pe <= (rx_load && par_bad) ? 1'b1 : (rd_sta ? 1'b0 : pe);
      fe <= (rx_load && !rx_bit) ? 1'b1 : (rd_sta ? 1'b0 : fe);
      bi <= bi_hit ? 1'b1 : (rd_sta ? 1'b0 : bi);
    end

  wire thre = ~thr_full;
  wire temt = ~thr_full & ~tx_busy;

  always_comb
    case (addr)
      2'd0:    rdata = rbr;
      2'd1:    rdata = {3'b000, lb, 2'b00, rts, dtr};
      2'd2:    rdata = {1'b0, temt, thre, bi, fe, pe, oe, dr};
      default: rdata = 8'h00;
    endcase
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] wmodem,
  input logic       tx_o,
  input logic       rts_n_o,
  input logic       dtr_n_o,
  input logic       lb,
  input logic       thr_full,
  input logic       tx_busy,
  input logic       rx_load,
  input logic       bi_hit,
  input logic       dr,
  input logic       oe,
  input logic       pe,
  input logic       fe,
  input logic       bi
);
  assert_thr_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> thr_full);

  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && !lb && $past(!lb)) |-> $past(tx_o));

  assert_loop_park_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lb |-> tx_o);

  assert_dr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !rx_load) |=> !dr);

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && dr && !(rd_en && addr == 2'd0)) |=> oe);

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2 && !rx_load && !bi_hit) |=> !(oe || pe || fe || bi));

  assert_rts_pin_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (rts_n_o == !$past(wmodem[1])));

  assert_dtr_pin_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (dtr_n_o == !$past(wmodem[0])));
endmodule

bind uart_core uart_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wmodem(wdata[1:0]), .tx_o(tx_o), .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o),
  .lb(lb), .thr_full(thr_full), .tx_busy(tx_busy), .rx_load(rx_load),
  .bi_hit(bi_hit), .dr(dr), .oe(oe), .pe(pe), .fe(fe), .bi(bi)
);

// File: tb/sim_uart_core.sv
module sim_uart_core;
  localparam int CLK_DIV   = 4;
  localparam int OVS       = 16;
  localparam int BITC      = CLK_DIV * OVS;
  localparam int FRAME     = 11;
  localparam int FRAME_CYC = FRAME * BITC;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rx_i = 1'b1;
  logic [1:0] addr = 2'd2;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tx_o, rts_n_o, dtr_n_o;

  uart_core #(.CLK_DIV(CLK_DIV), .OVS(OVS), .PARITY_EN(1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_i(rx_i), .tx_o(tx_o),
    .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o));

  always #4 clk = ~clk;

  int  vecs = 0, errs = 0;
  bit  done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  int        m_div, m_cyc;
  bit        m_full, m_busy, m_tick;
  logic [7:0]  m_thr, m_ctrl;
  logic [10:0] m_frame;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cyc = 0; m_full = 0; m_busy = 0;
      m_thr = 0; m_ctrl = 0; m_frame = '1;
    end else begin
      m_tick = (m_div == CLK_DIV - 1);
      m_div  = m_tick ? 0 : m_div + 1;
      if (m_busy) begin
        m_cyc++;
        if (m_cyc == FRAME_CYC) m_busy = 0;
      end else if (m_tick && m_full) begin
        m_frame = {1'b1, ^m_thr, m_thr, 1'b0};
        m_busy = 1; m_cyc = 0; m_full = 0;
      end
      if (wr_en && addr == 2'd0) begin m_full = 1; m_thr = wdata; end
      if (wr_en && addr == 2'd1) m_ctrl = wdata & 8'h13;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R2/R12 tx_o", tx_o,
            m_ctrl[4] ? 1 : (m_busy ? int'(m_frame[m_cyc / BITC]) : 1));
      check("R13 rts_n_o", rts_n_o, !m_ctrl[1]);
      check("R13 dtr_n_o", dtr_n_o, !m_ctrl[0]);
      if (addr == 2'd2) begin
        check("R3 holding-empty", rdata[5], !m_full);
        check("R4 all-empty", rdata[6], !m_full && !m_busy);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; addr = 2'd2;
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [10:0] f;
    f = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk); rx_i = f[i];
      repeat (BITC - 1) @(negedge clk);
    end
    @(negedge clk); rx_i = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [7:0] v;
  initial begin
    repeat (5) @(negedge clk);
    check("R1 tx_o at reset", tx_o, 1);
    check("R1 rts_n_o at reset", rts_n_o, 1);
    check("R1 dtr_n_o at reset", dtr_n_o, 1);
    rst_n = 1'b1;
    rd(2'd2, v); check("R1 status reset", v, 8'h60);
    rd(2'd1, v); check("R1 control reset", v, 8'h00);

    wr(2'd1, 8'h03); rd(2'd1, v); check("R13 control readback", v, 8'h03);
    check("R13 rts low", rts_n_o, 0);
    check("R13 dtr low", dtr_n_o, 0);
    wr(2'd1, 8'hEF); rd(2'd1, v); check("R13 reserved bits read zero", v, 8'h03);
    wr(2'd1, 8'h02); rd(2'd1, v); check("R13 control readback 2", v, 8'h02);
    check("R13 dtr high", dtr_n_o, 1);
    wr(2'd1, 8'h00);

    wr(2'd0, 8'hA5);
    repeat (100) @(negedge clk);
    rd(2'd2, v); check("R3/R4 mid-frame flags", v[6:5], 2'b01);
    wr(2'd0, 8'h3C);
    rd(2'd2, v); check("R3 holding full", v[5], 0);
    repeat (2 * FRAME_CYC + 50) @(negedge clk);
    rd(2'd2, v); check("R4 transmitter idle", v, 8'h60);

    wr(2'd1, 8'h10);
    rx_i = 1'b0;
    wr(2'd0, 8'h11);
    repeat (100) @(negedge clk);
    wr(2'd0, 8'h22);
    wr(2'd0, 8'h33);
    repeat (FRAME_CYC) @(negedge clk);
    rd(2'd0, v); check("R12 loopback char", v, 8'h11);
    repeat (FRAME_CYC) @(negedge clk);
    rd(2'd0, v); check("R5 overwritten pending byte", v, 8'h33);
    rd(2'd2, v); check("R12 rx_i ignored, no errors", v, 8'h60);
    rx_i = 1'b1;
    wr(2'd1, 8'h00);
    repeat (20) @(negedge clk);

    send(8'h3C, 0, 0); repeat (10) @(negedge clk);
    rd(2'd2, v); check("R6 data ready", v, 8'h61);
    rd(2'd0, v); check("R6 received byte", v, 8'h3C);
    rd(2'd2, v); check("R6 data ready cleared", v, 8'h60);

    send(8'h81, 1, 0); repeat (10) @(negedge clk);
    rd(2'd2, v); check("R7 parity error", v, 8'h65);
    rd(2'd2, v); check("R11 error cleared, DR kept", v, 8'h61);
    rd(2'd0, v); check("R7 byte with bad parity", v, 8'h81);

    send(8'h7E, 0, 1); repeat (10) @(negedge clk);
    rd(2'd2, v); check("R8 framing error", v, 8'h69);
    rd(2'd0, v); check("R8 byte with bad stop", v, 8'h7E);
    rd(2'd2, v); check("R11 framing cleared", v, 8'h60);

    send(8'h12, 0, 0); send(8'h34, 0, 0); repeat (10) @(negedge clk);
    rd(2'd2, v); check("R9 overrun", v, 8'h63);
    rd(2'd0, v); check("R9 newest byte kept", v, 8'h34);

    @(negedge clk); rx_i = 1'b0;
    repeat (16) @(negedge clk); rx_i = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    rd(2'd2, v); check("R14 short glitch rejected", v, 8'h60);

    send(8'h00, 0, 0); repeat (10) @(negedge clk);
    rd(2'd2, v); check("R10 zero char sets no break", v, 8'h61);
    rd(2'd0, v); check("R10 zero char data", v, 8'h00);

    @(negedge clk); rx_i = 1'b0;
    repeat (BITC * 13) @(negedge clk); rx_i = 1'b1;
    repeat (BITC) @(negedge clk);
    rd(2'd2, v); check("R10 break detected", v, 8'h79);
    rd(2'd0, v); check("R10 break char", v, 8'h00);
    rd(2'd2, v); check("R11 break cleared", v, 8'h60);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule